// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one active-low external interrupt pin on behalf of a CPU. The pin passes through a synchronizer, and a falling edge sets a request latch. The CPU request output is the latch gated by a mask bit. The latch is cleared by a vector-fetch strobe from the core or by software writing the acknowledge bit. A mode bit selects edge-only sensing or edge-plus-level sensing. In edge-plus-level mode the request stays pending while the pin is held low, so it only clears once an acknowledge has been seen and the pin has also gone high again. Those two events may happen in either order.

Software reaches the block through a single 8-bit status/control register. Reads return the flag, mask and mode bits. A write updates mask and mode, and it can also acknowledge. While a debug break is active, software acknowledges are discarded unless a break-clear-enable input permits them. A clear made during the break persists after the break ends. The block also presents a constant vector address and a synchronized pin level for software to test.

Top module: `irq_ext_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and the CPU request is low. This holds even when the pin is held low through reset and afterwards, because an edge is only seen after the pin has been observed high.
- R2: A falling edge on the pin sets the flag (register bit 3) on the third rising clock edge after the pin changes. The flag is still clear after the second rising edge.
- R3: With mode (register bit 0) at 0, a vector-fetch strobe or a software write with bit 2 set clears the flag on the next clock edge, even while the pin stays low.
- R4: With mode at 1, the flag clears only after both an acknowledge and a synchronized high pin level have occurred. If the acknowledge comes first, the clear lands on the third clock edge after the pin rises. If the pin is already high, the acknowledge clears the flag at once.
- R5: The CPU request is high exactly when the flag is set and the mask (register bit 1) is 0. The flag stays readable while the mask is 1.
- R6: Register bits 7:4 and the acknowledge bit 2 always read 0. Bits 1 and 0 read back the last values written.
- R7: An acknowledge does not block later edges, and a new falling edge sets the flag again. When an edge and an acknowledge land on the same clock edge, the flag stays set.
- R8: While break is active and the break-clear-enable input is 0, a software acknowledge leaves the flag unchanged. With the enable at 1 the acknowledge clears the flag, and the flag stays clear after break ends.
- R9: The vector address output is the constant 0xFFFA.
- R10: The pin-level output follows the pin two clock edges after it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| reg_wr_en | input | 1 | Write strobe for the status/control register |
| reg_wdata | input | 8 | Write data: bit 2 acknowledge, bit 1 mask, bit 0 mode |
| reg_rdata | output | 8 | Read data: bit 3 flag, bit 1 mask, bit 0 mode, others 0 |
| vec_fetch_ack | input | 1 | One-cycle strobe from the core when it fetches the vector |
| break_active | input | 1 | Debug break state is in force |
| break_clr_en | input | 1 | Allows software acknowledges during break |
| cpu_irq_req | output | 1 | Interrupt request to the CPU |
| irq_vector_addr | output | 16 | Constant vector address |
| pin_level | output | 1 | Synchronized pin level for software |

## Verification
The hardest case to reach from the ports is the same-cycle collision of an edge and an acknowledge. The edge appears inside the block two synchronizer stages after the pin moves, so the bench counts clock edges from the pin change and places the register write so that it covers exactly the third rising edge. Level-mode pending clears are also hard to reach. For these the bench holds the pin low across the acknowledge and then releases it, so that both orders of the two clearing events are produced.

// File: rtl/irq_ext_pkg.sv
package irq_ext_pkg;

  localparam int REG_W     = 8;
  localparam int BIT_MODE  = 0;
  localparam int BIT_MASK  = 1;
  localparam int BIT_ACK   = 2;
  localparam int BIT_FLAG  = 3;

  typedef struct packed {
    logic mask;
    logic mode;
  } irq_ctl_t;

  // falling edge of an active-low pin: previously high, now low
  function automatic logic fall_detect(input logic prev_lvl, input logic cur_lvl);
    return prev_lvl & ~cur_lvl;
  endfunction

  // status image seen by software
  function automatic logic [REG_W-1:0] pack_status(input logic flag, input irq_ctl_t ctl);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_FLAG] = flag;
    v[BIT_MASK] = ctl.mask;
    v[BIT_MODE] = ctl.mode;
    return v;
  endfunction

  // a software acknowledge counts unless break suppresses it
  function automatic logic sw_ack_ok(input logic wr, input logic ack_bit,
                                     input logic brk, input logic brk_en);
    return wr & ack_bit & (~brk | brk_en);
  endfunction

  // level mode needs the pin back high before clearing
  function automatic logic clear_allowed(input logic mode, input logic pin_hi);
    return ~mode | pin_hi;
  endfunction

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign prev_o  = prev_q;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_ext_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  input  logic ack_i,
  input  logic mode_i,
  input  logic pin_hi_i,
  output logic latch_o,
  output logic pend_o,
  output logic clear_o
);
  logic latch_q, pend_q;
  logic clr_ok;

  assign clr_ok  = clear_allowed(mode_i, pin_hi_i);
  assign clear_o = latch_q & ~edge_i & (ack_i | pend_q) & clr_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (edge_i) begin
      latch_q <= 1'b1;
      pend_q  <= 1'b0;
    end else if (clear_o) begin
      latch_q <= 1'b0;
      pend_q  <= 1'b0;
    end else if (latch_q && ack_i) begin
      pend_q  <= 1'b1;
    end else if (!latch_q) begin
      pend_q  <= 1'b0;
    end
  end

  assign latch_o = latch_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_ext_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             brk_i,
  input  logic             brk_en_i,
  input  logic             flag_i,
  output logic [REG_W-1:0] rdata_o,
  output irq_ctl_t         ctl_o,
  output logic             sw_ack_o
);
  irq_ctl_t ctl_q;
  logic     unused_wbits;

  assign unused_wbits = ^wdata_i[REG_W-1:BIT_FLAG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (wr_en_i) begin
      ctl_q.mask <= wdata_i[BIT_MASK];
      ctl_q.mode <= wdata_i[BIT_MODE];
    end
  end

  assign sw_ack_o = sw_ack_ok(wr_en_i, wdata_i[BIT_ACK], brk_i, brk_en_i);
  assign rdata_o  = pack_status(flag_i, ctl_q);
  assign ctl_o    = ctl_q;
endmodule

// File: rtl/irq_ext_ctrl.sv
module irq_ext_ctrl
  import irq_ext_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VECTOR_ADDR = 16'hFFFA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_pin_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             vec_fetch_ack,
  input  logic             break_active,
  input  logic             break_clr_en,
  output logic             cpu_irq_req,
  output logic [15:0]      irq_vector_addr,
  output logic             pin_level
);
  logic     pin_sync, pin_prev;
  logic     edge_evt, ack_evt, sw_ack;
  logic     latch_q, pend_q, clear_evt;
  irq_ctl_t ctl;

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (irq_pin_n),
    .level_o (pin_sync),
    .prev_o  (pin_prev)
  );

  assign edge_evt = fall_detect(pin_prev, pin_sync);
  assign ack_evt  = vec_fetch_ack | sw_ack;

  irq_req_latch u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .edge_i   (edge_evt),
    .ack_i    (ack_evt),
    .mode_i   (ctl.mode),
    .pin_hi_i (pin_sync),
    .latch_o  (latch_q),
    .pend_o   (pend_q),
    .clear_o  (clear_evt)
  );

  irq_ctrl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (reg_wr_en),
    .wdata_i  (reg_wdata),
    .brk_i    (break_active),
    .brk_en_i (break_clr_en),
    .flag_i   (latch_q),
    .rdata_o  (reg_rdata),
    .ctl_o    (ctl),
    .sw_ack_o (sw_ack)
  );

  assign cpu_irq_req     = latch_q & ~ctl.mask;
  assign irq_vector_addr = VECTOR_ADDR;
  assign pin_level       = pin_sync;
endmodule

// File: rtl/irq_ext_ctrl_chk.sv
module irq_ext_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       edge_evt,
  input logic       ack_evt,
  input logic       latch_q,
  input logic       pin_sync,
  input logic       mode,
  input logic       reg_wr_en,
  input logic [7:0] reg_wdata,
  input logic       vec_fetch_ack,
  input logic       break_active,
  input logic       break_clr_en,
  input logic       cpu_irq_req,
  input logic [7:0] reg_rdata
);
  p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> latch_q);

  p_edge_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_evt && ack_evt && !mode) |=> !latch_q);

  p_level_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && mode && !pin_sync) |=> latch_q);

  p_req_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq_req |-> reg_rdata[3]);

  p_ack_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wdata[2]) |=> (reg_rdata[2] == 1'b0));

  p_break_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && break_active && !break_clr_en && !vec_fetch_ack && !(mode && pin_sync))
      |=> latch_q);
endmodule

bind irq_ext_ctrl irq_ext_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .edge_evt      (edge_evt),
  .ack_evt       (ack_evt),
  .latch_q       (latch_q),
  .pin_sync      (pin_sync),
  .mode          (ctl.mode),
  .reg_wr_en     (reg_wr_en),
  .reg_wdata     (reg_wdata),
  .vec_fetch_ack (vec_fetch_ack),
  .break_active  (break_active),
  .break_clr_en  (break_clr_en),
  .cpu_irq_req   (cpu_irq_req),
  .reg_rdata     (reg_rdata)
);

// File: tb/irq_ext_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ext_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irq_pin_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       vec_fetch_ack = 1'b0;
  logic       break_active = 1'b0;
  logic       break_clr_en = 1'b0;
  logic       cpu_irq_req;
  logic [15:0] irq_vector_addr;
  logic       pin_level;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [1:0] ctl_sh = 2'b00;   // {mask, mode}

  always #10 clk = ~clk;

  irq_ext_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .vec_fetch_ack(vec_fetch_ack), .break_active(break_active),
    .break_clr_en(break_clr_en), .cpu_irq_req(cpu_irq_req),
    .irq_vector_addr(irq_vector_addr), .pin_level(pin_level)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic ack, input logic mask, input logic mode);
    ctl_sh = {mask, mode};
    reg_wdata = {5'b0, ack, mask, mode};
    reg_wr_en = 1'b1;
    tick(1);
    reg_wr_en = 1'b0;
    reg_wdata = 8'h00;
  endtask

  task automatic vfetch();
    vec_fetch_ack = 1'b1;
    tick(1);
    vec_fetch_ack = 1'b0;
  endtask

  task automatic pin_high_settle();
    irq_pin_n = 1'b1;
    tick(4);
  endtask

  task automatic fire_edge();
    irq_pin_n = 1'b0;
    tick(4);
  endtask

  task automatic t_reset();
    // pin held low through reset and after: R1
    tick(3);
    rst_n = 1'b1;
    tick(6);
    check({8'h0, reg_rdata}, 16'h0000, "R1 reset register");
    check({15'h0, cpu_irq_req}, 16'h0, "R1 no request with pin low");
    check(irq_vector_addr, 16'hFFFA, "R9 vector address");
  endtask

  task automatic t_sync_and_edge();
    irq_pin_n = 1'b1;
    tick(2);
    check({15'h0, pin_level}, 16'h1, "R10 pin level after two edges");
    tick(2);
    irq_pin_n = 1'b0;
    tick(2);
    check({15'h0, reg_rdata[3]}, 16'h0, "R2 flag clear after two edges");
    tick(1);
    check({15'h0, reg_rdata[3]}, 16'h1, "R2 flag set on third edge");
    check({15'h0, cpu_irq_req}, 16'h1, "R5 request unmasked");
  endtask

  task automatic t_edge_mode_ack();
    wr(1'b1, 1'b0, 1'b0);
    check({15'h0, reg_rdata[3]}, 16'h0, "R3 sw ack clears with pin low");
    pin_high_settle();
    fire_edge();
    vfetch();
    check({15'h0, reg_rdata[3]}, 16'h0, "R3 vector fetch clears");
  endtask

  task automatic t_mask_and_fields();
    pin_high_settle();
    fire_edge();
    wr(1'b0, 1'b1, 1'b0);
    check({15'h0, cpu_irq_req}, 16'h0, "R5 masked request low");
    check({15'h0, reg_rdata[3]}, 16'h1, "R5 flag visible while masked");
    check({8'h0, reg_rdata}, 16'h000A, "R6 readback flag+mask, ack reads 0");
    wr(1'b1, 1'b0, 1'b1);
    check({8'h0, reg_rdata & 8'hF7}, 16'h0001, "R6 mode readback, upper bits 0");
    wr(1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_level_ack_first();
    wr(1'b0, 1'b0, 1'b1);
    pin_high_settle();
    fire_edge();
    wr(1'b1, 1'b0, 1'b1);
    check({15'h0, reg_rdata[3]}, 16'h1, "R4 ack with pin low keeps flag");
    tick(3);
    check({15'h0, cpu_irq_req}, 16'h1, "R4 request held while low");
    irq_pin_n = 1'b1;
    tick(2);
    check({15'h0, reg_rdata[3]}, 16'h1, "R4 still set two edges after rise");
    tick(1);
    check({15'h0, reg_rdata[3]}, 16'h0, "R4 cleared third edge after rise");
  endtask

  task automatic t_level_pin_first();
    fire_edge();
    irq_pin_n = 1'b1;
    tick(4);
    check({15'h0, reg_rdata[3]}, 16'h1, "R4 pin high alone keeps flag");
    vfetch();
    check({15'h0, reg_rdata[3]}, 16'h0, "R4 ack after release clears");
    wr(1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_collision_and_reedge();
    pin_high_settle();
    irq_pin_n = 1'b0;
    tick(2);
    wr(1'b1, 1'b0, 1'b0);   // write covers the third edge, same as the edge event
    check({15'h0, reg_rdata[3]}, 16'h1, "R7 edge wins over same-cycle ack");
    wr(1'b1, 1'b0, 1'b0);
    check({15'h0, reg_rdata[3]}, 16'h0, "R7 later ack clears");
    pin_high_settle();
    fire_edge();
    check({15'h0, reg_rdata[3]}, 16'h1, "R7 new edge after ack sets again");
  endtask

  task automatic t_break();
    break_active = 1'b1;
    break_clr_en = 1'b0;
    wr(1'b1, 1'b0, 1'b0);
    check({15'h0, reg_rdata[3]}, 16'h1, "R8 ack ignored in break");
    break_clr_en = 1'b1;
    wr(1'b1, 1'b0, 1'b0);
    check({15'h0, reg_rdata[3]}, 16'h0, "R8 ack allowed in break");
    break_active = 1'b0;
    break_clr_en = 1'b0;
    tick(3);
    check({15'h0, reg_rdata[3]}, 16'h0, "R8 stays clear after break");
  endtask

  initial begin
    tick(1);
    t_reset();
    t_sync_and_edge();
    t_edge_mode_ack();
    t_mask_and_fields();
    t_level_ack_first();
    t_level_pin_first();
    t_collision_and_reedge();
    t_break();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule